// File: doc/BRIEF.md
# Coprocessor memory access guard

The block sits on the host CPU bus in front of a coprocessor's on-chip RAM and register window. The window starts at host byte address 0xFFFE0000. It maps the RAM as rows of two 16-bit words: word n occupies byte offset 2n (low byte) and 2n+1 (high byte). A bank of 16 registers sits at window offset 0x1F000, one register per 4-byte row. The host may issue byte, 16-bit or 32-bit accesses at any alignment. An access that stays inside one 4-byte row completes in the cycle it is requested. An access that spills into the next row is carried out as two row cycles and is answered in the second.

While the coprocessor's command-list engine reports busy, only registers 0 to 5 remain open to the host. These are list status, external control, interrupt mask, interrupt, NMI status (index 4, held inside this block) and abort. Any other access into the window is blocked:
- a blocked write reaches neither the RAM nor the registers;
- a blocked read returns 0xDEAD in every 16-bit word position;
- a blocked access sets a sticky error flag, sends a one-cycle NMI request to the host, and sends a one-cycle abort to the engine.

The RAM array, the register file and the engine are outside the block and are reached through plain strobe ports.

Top module: `coproc_mem_guard`

## Requirements
- R1: With busy_i low, a window access at byte offset o below the RAM size strobes ram_en_o for row o[16:2], with byte o on lane o[1:0] (bits 8*o[1:0]+7 down to 8*o[1:0]). An access to register row k (offset 0x1F000+4k, k not 4) strobes reg_en_o with reg_idx_o = k. Writes land only in the enabled byte lanes, and reads return the stored bytes.
- R2: host_size_i encodes 0 as byte, 1 as 16-bit and 2 as 32-bit. Write data and read data are right-justified on the host bus, and read bits above the access size are zero. All sizes work at all four byte alignments.
- R3: An access whose bytes fit in one 4-byte row asserts host_ack_o in the same cycle as host_req_i.
- R4: An access that crosses a row boundary takes two cycles, with ack in the second cycle. The lower row is served first, and the read data joins the bytes of both rows.
- R5: While busy_i is high, registers 0 to 5 still read and write normally, including a split access that touches only those registers.
- R6: While busy_i is high, a write to any other window location produces no ram_en_o or reg_en_o strobe and leaves the stored contents unchanged.
- R7: While busy_i is high, a read of any other window location returns 0xAD for each byte at an even address and 0xDE for each byte at an odd address.
- R8: A blocked access drives nmi_o and abort_o high for exactly the one cycle that follows its ack.
- R9: The error flag reads as bit 0 of register 4. It is set by a blocked access and stays set until the host writes 1 to bit 0 of register 4. Writing 0 to that bit has no effect. The flag is 0 after reset.
- R10: A request outside the window gets no ack and produces no strobe.
- R11: With busy_i low, a window offset that is neither RAM nor a register reads as zero, and a write there produces no strobe.
- R12: The block/allow decision for a split access is taken once, in its first cycle, for both rows. If either row is blocked, both are blocked, and only one NMI pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Command-list engine running |
| host_req_i | input | 1 | Host access request, held until ack |
| host_we_i | input | 1 | Host write when high |
| host_addr_i | input | 32 | Host byte address |
| host_size_i | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| host_wdata_i | input | 32 | Host write data, right-justified |
| host_ack_o | output | 1 | Access complete |
| host_rdata_o | output | 32 | Read data, right-justified, valid with ack |
| ram_en_o | output | 1 | RAM row strobe |
| ram_row_o | output | 6 | RAM row index |
| reg_en_o | output | 1 | Register strobe |
| reg_idx_o | output | 4 | Register index |
| mem_we_o | output | 1 | Write for the strobed row |
| mem_be_o | output | 4 | Byte enables of the strobed row |
| mem_wdata_o | output | 32 | Lane-aligned write data |
| ram_rdata_i | input | 32 | RAM row read data, combinational |
| reg_rdata_i | input | 32 | Register read data, combinational |
| nmi_o | output | 1 | NMI request pulse to the host |
| abort_o | output | 1 | Abort pulse to the engine |

## Verification
A wrong lane shift or a bad row index shows up in the cycle the access is acked. It appears either as misplaced bytes in host_rdata_o or as a strobe carrying the wrong byte enables, and a read-back of the same bytes exposes it. A stale split state or a blocking decision re-evaluated between the two row cycles shows up as an ack that is late or early, as strobes during a blocked split, or as a second NMI pulse. A broken error flag shows up only through register 4, so it is read before and after each set and clear.

// File: rtl/gd_pkg.sv
`timescale 1ns/1ps
package gd_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_RAM  = 2'd1,
    RG_REG  = 2'd2
  } region_e;

  localparam logic [31:0] BLOCKED_ROW = 32'hDEAD_DEAD;
endpackage

// File: rtl/gd_lane_map.sv
`timescale 1ns/1ps
module gd_lane_map
  import gd_pkg::*;
(
  input  logic [1:0]  ofs_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] rd_lo_i,
  input  logic [31:0] rd_hi_i,
  output logic [3:0]  be_lo_o,
  output logic [3:0]  be_hi_o,
  output logic [31:0] wd_lo_o,
  output logic [31:0] wd_hi_o,
  output logic [31:0] rdata_o,
  output logic        split_o
);
  logic [3:0]  size_mask;
  logic [7:0]  pair_mask;
  logic [63:0] pair_wd;
  logic [31:0] bit_mask;

  always_comb begin
    case (size_i)
      SZ_BYTE: size_mask = 4'b0001;
      SZ_WORD: size_mask = 4'b0011;
      default: size_mask = 4'b1111;
    endcase
  end

  assign pair_mask = 8'({4'b0000, size_mask} << ofs_i);
  assign pair_wd   = 64'({32'h0, wdata_i} << {ofs_i, 3'b000});
  assign be_lo_o   = pair_mask[3:0];
  assign be_hi_o   = pair_mask[7:4];
  assign wd_lo_o   = pair_wd[31:0];
  assign wd_hi_o   = pair_wd[63:32];
  assign split_o   = |pair_mask[7:4];

  for (genvar b = 0; b < 4; b++) begin : g_bmask
    assign bit_mask[8*b +: 8] = {8{size_mask[b]}};
  end

  assign rdata_o = 32'({rd_hi_i, rd_lo_i} >> {ofs_i, 3'b000}) & bit_mask;
endmodule

// File: rtl/gd_row_decode.sv
`timescale 1ns/1ps
module gd_row_decode
  import gd_pkg::*;
#(
  parameter int unsigned ROW_W    = 15,
  parameter int unsigned RAM_ROWS = 64,
  parameter int unsigned NREGS    = 16,
  parameter int unsigned EXEMPT   = 6,
  parameter int unsigned NMI_IDX  = 4,
  parameter logic [ROW_W-1:0] REG_ROW0 = 15'h7C00,
  localparam int unsigned RAM_AW  = $clog2(RAM_ROWS),
  localparam int unsigned REG_IW  = $clog2(NREGS)
) (
  input  logic [ROW_W-1:0]  row_i,
  input  logic              touch_i,
  output region_e           region_o,
  output logic [RAM_AW-1:0] ram_row_o,
  output logic [REG_IW-1:0] reg_idx_o,
  output logic              is_nmi_o,
  output logic              guarded_o
);
  logic in_ram, in_reg, exempt;

  assign in_ram    = (row_i[ROW_W-1:RAM_AW] == '0);
  assign in_reg    = (row_i[ROW_W-1:REG_IW] == REG_ROW0[ROW_W-1:REG_IW]);
  assign ram_row_o = row_i[RAM_AW-1:0];
  assign reg_idx_o = row_i[REG_IW-1:0];
  assign region_o  = in_ram ? RG_RAM : (in_reg ? RG_REG : RG_NONE);
  assign is_nmi_o  = in_reg && (reg_idx_o == REG_IW'(NMI_IDX));
  assign exempt    = in_reg && (reg_idx_o < REG_IW'(EXEMPT));
  assign guarded_o = touch_i && !exempt;
endmodule

// File: rtl/gd_nmi_status.sv
`timescale 1ns/1ps
module gd_nmi_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o,
  output logic pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= set_i;
      if (set_i)      err_o <= 1'b1;
      else if (clr_i) err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/coproc_mem_guard.sv
`timescale 1ns/1ps
module coproc_mem_guard
  import gd_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR   = 32'hFFFE_0000,
  parameter int unsigned WIN_AW      = 17,
  parameter int unsigned RAM_ROWS    = 64,
  parameter logic [31:0] REG_OFS     = 32'h0001_F000,
  parameter int unsigned NREGS       = 16,
  parameter int unsigned EXEMPT_REGS = 6,
  parameter int unsigned NMI_IDX     = 4,
  localparam int unsigned ROW_W      = WIN_AW - 2,
  localparam int unsigned RAM_AW     = $clog2(RAM_ROWS),
  localparam int unsigned REG_IW     = $clog2(NREGS),
  localparam logic [ROW_W-1:0] REG_ROW0 = REG_OFS[WIN_AW-1:2]
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [31:0]       host_addr_i,
  input  logic [1:0]        host_size_i,
  input  logic [31:0]       host_wdata_i,
  output logic              host_ack_o,
  output logic [31:0]       host_rdata_o,
  output logic              ram_en_o,
  output logic [RAM_AW-1:0] ram_row_o,
  output logic              reg_en_o,
  output logic [REG_IW-1:0] reg_idx_o,
  output logic              mem_we_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       ram_rdata_i,
  input  logic [31:0]       reg_rdata_i,
  output logic              nmi_o,
  output logic              abort_o
);
  logic              in_win, active, split, blk_now, blk;
  logic              second_q, blk_q;
  logic [31:0]       lo_q;
  logic [ROW_W-1:0]  row_v   [2];
  logic              touch_v [2];
  region_e           rgn_v   [2];
  logic [RAM_AW-1:0] ram_v   [2];
  logic [REG_IW-1:0] idx_v   [2];
  logic              nmi_v   [2];
  logic              grd_v   [2];
  logic [3:0]        be_lo, be_hi, cur_be;
  logic [31:0]       wd_lo, wd_hi, cur_wd;
  logic [31:0]       row_rd, rd_lo, rd_hi, mapped;
  region_e           cur_rgn;
  logic              cur_nmi, pass, err, pulse, set_err, clr_err;

  assign in_win   = (host_addr_i[31:WIN_AW] == BASE_ADDR[31:WIN_AW]);
  assign active   = host_req_i && in_win;
  assign row_v[0] = host_addr_i[WIN_AW-1:2];
  assign row_v[1] = host_addr_i[WIN_AW-1:2] + ROW_W'(1);
  assign touch_v[0] = |be_lo;
  assign touch_v[1] = |be_hi;

  gd_lane_map i_lanes (
    .ofs_i   (host_addr_i[1:0]),
    .size_i  (host_size_i),
    .wdata_i (host_wdata_i),
    .rd_lo_i (rd_lo),
    .rd_hi_i (rd_hi),
    .be_lo_o (be_lo),
    .be_hi_o (be_hi),
    .wd_lo_o (wd_lo),
    .wd_hi_o (wd_hi),
    .rdata_o (mapped),
    .split_o (split)
  );

  for (genvar r = 0; r < 2; r++) begin : g_row
    gd_row_decode #(
      .ROW_W    (ROW_W),
      .RAM_ROWS (RAM_ROWS),
      .NREGS    (NREGS),
      .EXEMPT   (EXEMPT_REGS),
      .NMI_IDX  (NMI_IDX),
      .REG_ROW0 (REG_ROW0)
    ) i_dec (
      .row_i     (row_v[r]),
      .touch_i   (touch_v[r]),
      .region_o  (rgn_v[r]),
      .ram_row_o (ram_v[r]),
      .reg_idx_o (idx_v[r]),
      .is_nmi_o  (nmi_v[r]),
      .guarded_o (grd_v[r])
    );
  end

  // decision covers both rows, frozen for the second cycle
  assign blk_now = busy_i && (grd_v[0] || grd_v[1]);
  assign blk     = second_q ? blk_q : blk_now;

  assign cur_rgn = second_q ? rgn_v[1] : rgn_v[0];
  assign cur_nmi = second_q ? nmi_v[1] : nmi_v[0];
  assign cur_be  = second_q ? be_hi    : be_lo;
  assign cur_wd  = second_q ? wd_hi    : wd_lo;
  assign pass    = active && !blk && (|cur_be);

  assign ram_en_o    = pass && (cur_rgn == RG_RAM);
  assign reg_en_o    = pass && (cur_rgn == RG_REG) && !cur_nmi;
  assign ram_row_o   = second_q ? ram_v[1] : ram_v[0];
  assign reg_idx_o   = second_q ? idx_v[1] : idx_v[0];
  assign mem_we_o    = host_we_i;
  assign mem_be_o    = cur_be;
  assign mem_wdata_o = cur_wd;

  always_comb begin
    case (cur_rgn)
      RG_RAM:  row_rd = ram_rdata_i;
      RG_REG:  row_rd = cur_nmi ? {31'h0, err} : reg_rdata_i;
      default: row_rd = 32'h0;
    endcase
    if (blk) row_rd = BLOCKED_ROW;
  end

  assign rd_lo        = second_q ? lo_q : row_rd;
  assign rd_hi        = second_q ? row_rd : 32'h0;
  assign host_ack_o   = active && (second_q || !split);
  assign host_rdata_o = (host_ack_o && !host_we_i) ? mapped : 32'h0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q <= 1'b0;
      blk_q    <= 1'b0;
      lo_q     <= 32'h0;
    end else if (!second_q) begin
      if (active && split) begin
        second_q <= 1'b1;
        blk_q    <= blk_now;
        lo_q     <= row_rd;
      end
    end else if (host_ack_o || !host_req_i) begin
      second_q <= 1'b0;
    end
  end

  assign set_err = host_ack_o && blk;
  assign clr_err = pass && (cur_rgn == RG_REG) && cur_nmi && host_we_i
                   && cur_be[0] && cur_wd[0];

  gd_nmi_status i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_err),
    .clr_i   (clr_err),
    .err_o   (err),
    .pulse_o (pulse)
  );

  assign nmi_o   = pulse;
  assign abort_o = pulse;

  // R8
  nmi_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> $past(host_ack_o));
  // R6
  no_ram_strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !second_q) |-> !ram_en_o);
  // R5
  exempt_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !second_q && reg_en_o) |-> (reg_idx_o < REG_IW'(EXEMPT_REGS)));
  // R10
  outside_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_addr_i[31:WIN_AW] != BASE_ADDR[31:WIN_AW])
      |-> !(host_ack_o || ram_en_o || reg_en_o));
  // R4
  split_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    second_q |-> $past(host_req_i && !host_ack_o));
  // R9
  err_clear_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err) |-> $past(host_we_i && host_ack_o));
endmodule

// File: tb/test_coproc_mem_guard.sv
`timescale 1ns/1ps
module test_coproc_mem_guard;
  localparam logic [31:0] BASE = 32'hFFFE_0000;
  localparam logic [31:0] REGA = 32'hFFFF_F000;
  localparam int RAM_BYTES = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic busy = 1'b0, req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [1:0] size = '0;
  logic ack, ram_en, reg_en, mem_we, nmi, abort_s;
  logic [31:0] rdata, mem_wdata, ram_rd, reg_rd;
  logic [5:0] ram_row;
  logic [3:0] reg_idx, mem_be;

  logic [31:0] ram_m [64];
  logic [31:0] reg_m [16];
  logic [7:0]  ram_sh [RAM_BYTES];
  logic [7:0]  reg_sh [64];
  bit exp_err = 0;
  bit done = 0;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  coproc_mem_guard i_coproc_mem_guard (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy),
    .host_req_i(req), .host_we_i(we), .host_addr_i(addr),
    .host_size_i(size), .host_wdata_i(wdata),
    .host_ack_o(ack), .host_rdata_o(rdata),
    .ram_en_o(ram_en), .ram_row_o(ram_row),
    .reg_en_o(reg_en), .reg_idx_o(reg_idx),
    .mem_we_o(mem_we), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .ram_rdata_i(ram_rd), .reg_rdata_i(reg_rd),
    .nmi_o(nmi), .abort_o(abort_s)
  );

  assign ram_rd = ram_m[ram_row];
  assign reg_rd = reg_m[reg_idx];

  always @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      if (ram_en && mem_we && mem_be[b]) ram_m[ram_row][8*b +: 8] <= mem_wdata[8*b +: 8];
      if (reg_en && mem_we && mem_be[b]) reg_m[reg_idx][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : ((sz == 2'd1) ? 2 : 4);
  endfunction

  function automatic logic [7:0] exp_byte(input int o);
    if (o < RAM_BYTES) return ram_sh[o];
    if (o >= 'h1F000 && o < 'h1F040) begin
      if (((o - 'h1F000) >> 2) == 4) return ((o & 3) == 0) ? {7'h0, exp_err} : 8'h0;
      return reg_sh[o - 'h1F000];
    end
    return 8'h0;
  endfunction

  task automatic run(input string tag, input bit w, input logic [31:0] a,
                     input logic [1:0] sz, input logic [31:0] wd,
                     input bit blk, input int exp_strb);
    int nb, cyc, strb, ecyc;
    bit inw;
    logic [31:0] got, exp;
    nb  = nbytes(sz);
    inw = (a[31:17] == BASE[31:17]);
    ecyc = !inw ? 0 : ((int'(a[1:0]) + nb > 4) ? 2 : 1);
    exp = '0;
    for (int k = 0; k < nb; k++) begin
      int o;
      o = int'((a + k) & 32'h1FFFF);
      if (inw && !w) exp[8*k +: 8] = blk ? ((o & 1) ? 8'hDE : 8'hAD) : exp_byte(o);
    end
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = wd;
    cyc = 0; strb = 0; got = '0;
    forever begin
      #1;
      cyc++;
      strb += int'(ram_en) + int'(reg_en);
      if (ack) begin got = rdata; break; end
      if (cyc == 4) begin cyc = 0; break; end
      @(negedge clk);
    end
    @(negedge clk);
    req = 1'b0;
    #1;
    chk({(ecyc == 2) ? "R4" : ((ecyc == 1) ? "R3" : "R10"), " cycles ", tag}, cyc, ecyc);
    if (!w) chk({tag, " rdata"}, got, exp);
    if (exp_strb >= 0) chk({tag, " strobes"}, strb, exp_strb);
    chk({"R8 nmi ", tag}, {31'h0, nmi}, {31'h0, blk});
    chk({"R8 abort ", tag}, {31'h0, abort_s}, {31'h0, blk});
    if (blk) exp_err = 1'b1;
    if (w && inw && !blk) begin
      for (int k = 0; k < nb; k++) begin
        int o;
        o = int'((a + k) & 32'h1FFFF);
        if (o < RAM_BYTES) ram_sh[o] = wd[8*k +: 8];
        else if (o >= 'h1F000 && o < 'h1F040) begin
          if (((o - 'h1F000) >> 2) == 4) begin
            if ((o & 3) == 0 && wd[8*k]) exp_err = 1'b0;
          end else reg_sh[o - 'h1F000] = wd[8*k +: 8];
        end
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin ram_m[i] = '0; reg_m[i % 16] = '0; reg_sh[i] = '0; end
    for (int i = 0; i < RAM_BYTES; i++) ram_sh[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset ack", {31'h0, ack}, 32'h0);
    chk("R9 reset nmi", {31'h0, nmi}, 32'h0);
    rst_n = 1'b1;
    run("R9 reset err", 0, REGA + 16, 2'd2, 0, 0, 0);

    // R2 sweep over alignments and sizes, with read-back
    for (int o = 0; o < 12; o++) begin
      for (int s = 0; s < 3; s++) begin
        logic [31:0] v;
        int ns;
        v  = 32'h9E37_79B9 * (o * 3 + s + 1);
        ns = (o % 4 + nbytes(2'(s)) > 4) ? 2 : 1;
        run("R2 wr", 1, BASE + o, 2'(s), v, 0, ns);
        run("R2 rd", 0, BASE + o, 2'(s), 0, 0, ns);
      end
    end
    for (int o = 0; o < 16; o += 4) run("R1 dword", 0, BASE + o, 2'd2, 0, 0, 1);
    run("R1 last row wr", 1, BASE + 252, 2'd2, 32'h0BAD_F00D, 0, 1);
    run("R1 last row rd", 0, BASE + 252, 2'd2, 0, 0, 1);

    // R1 register rows while idle
    run("R1 reg0 wr", 1, REGA, 2'd2, 32'h1111_2222, 0, 1);
    run("R1 reg7 wr", 1, REGA + 28, 2'd2, 32'h7777_8888, 0, 1);
    run("R1 reg7 rd", 0, REGA + 28, 2'd2, 0, 0, 1);
    run("R1 reg0 rd", 0, REGA, 2'd2, 0, 0, 1);

    // R11 unmapped inside window
    run("R11 unmapped wr", 1, BASE + 32'h100, 2'd2, 32'hFFFF_FFFF, 0, 0);
    run("R11 unmapped rd", 0, BASE + 32'h100, 2'd2, 0, 0, 0);
    // R10 outside window
    run("R10 outside wr", 1, 32'h0000_1000, 2'd2, 32'h1234_5678, 0, 0);

    // busy phase
    busy = 1'b1;
    run("R5 reg1 wr", 1, REGA + 4, 2'd1, 32'h0000_1234, 0, 1);
    run("R5 reg1 rd", 0, REGA + 4, 2'd1, 0, 0, 1);
    run("R6 blocked ram wr", 1, BASE, 2'd2, 32'hCAFE_F00D, 1, 0);
    repeat (2) @(negedge clk);
    #1 chk("R8 one cycle pulse", {31'h0, nmi}, 32'h0);
    run("R7 blocked dword rd", 0, BASE, 2'd2, 0, 1, 0);
    run("R7 blocked odd byte", 0, BASE + 1, 2'd0, 0, 1, 0);
    run("R7 blocked even byte", 0, BASE + 2, 2'd0, 0, 1, 0);
    run("R7 blocked reg7 rd", 0, REGA + 28, 2'd2, 0, 1, 0);
    run("R9 err set", 0, REGA + 16, 2'd2, 0, 0, 0);
    run("R12 split blocked wr", 1, REGA + 22, 2'd2, 32'h5555_AAAA, 1, 0);
    run("R12 split blocked rd", 0, REGA + 22, 2'd2, 0, 1, 0);
    run("R5 exempt split rd", 0, REGA + 2, 2'd2, 0, 0, 2);
    run("R9 write zero", 1, REGA + 16, 2'd1, 32'h0, 0, 0);
    run("R9 still set", 0, REGA + 16, 2'd2, 0, 0, 0);
    run("R9 write one", 1, REGA + 16, 2'd1, 32'h1, 0, 0);
    run("R9 cleared", 0, REGA + 16, 2'd2, 0, 0, 0);
    busy = 1'b0;
    run("R6 ram unchanged", 0, BASE, 2'd2, 0, 0, 1);
    run("R6 reg6 unchanged", 0, REGA + 24, 2'd2, 0, 0, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule